// File: doc/BRIEF.md
# Windowed event timer

The block measures how long after a trigger a monitored event first goes high. A falling edge on the trigger input, taken while the block is armed, opens a timing window whose length comes from the window-length input. A phase register is loaded with that length and is stepped down by one on every clock. Its sign bit is the timeout condition. The window closes on whichever comes first: a rising edge of the synchronised event, or the sign bit of the phase register going high.

When the window closes, the block captures the phase value at once. The elapsed cycle count is the latched window length minus the captured residue, reduced by a fixed latency-compensation constant and clamped at zero. The result appears on the outputs together with a hit or timeout flag and a one-cycle done strobe. The result then holds until the next window closes. Both asynchronous inputs pass through two-flop synchronisers.

Top module: `win_event_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `done_o`, `hit_o`, `timeout_o` and `elapsed_o` are all 0.
- R2: A window opens only on a falling edge of the synchronised trigger. Take T as the first edge that samples `trig_i` low after it was high. The window opens at edge T+2, provided `arm_i` is high at that edge.
- R3: Take E as the first edge that samples `evt_i` high after it was low, and D = E - T. If 1 <= D <= L+1, where L is the window length, then after edge E+2 the outputs are `hit_o`=1, `timeout_o`=0 and `elapsed_o` = max(D-2, 0). This holds with the default compensation constant of 1.
- R4: An event rise whose synchronised edge arrives while no window is open has no effect. This covers D <= 0.
- R5: If no qualifying event rise occurs, the window times out after edge T+L+4. The outputs are then `timeout_o`=1, `hit_o`=0 and `elapsed_o`=0. This holds for L=0 and for the largest length, 2^LEN_W-1.
- R6: `done_o` is high for exactly one cycle, in the cycle after the closing edge. After that the block idles, and further event rises cause no new `done_o` until another trigger falls.
- R7: A new trigger fall while a window is open restarts the window. Both the phase reload and the timing reference move to the new fall.
- R8: `elapsed_o`, `hit_o` and `timeout_o` change only on the edge that raises `done_o`. Between windows they hold their values.
- R9: A trigger fall while `arm_i` is low opens no window and produces no `done_o`.
- R10: The window length is latched when the window opens. Changing `win_len_i` while the window is open does not change its timeout or its elapsed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Asynchronous trigger; a falling edge opens a window |
| evt_i | input | 1 | Asynchronous monitored event |
| arm_i | input | 1 | Enables trigger falls to open windows |
| win_len_i | input | LEN_W | Window length in cycles |
| elapsed_o | output | LEN_W | Cycles from window opening to the event, compensated |
| hit_o | output | 1 | Last window closed on an event |
| timeout_o | output | 1 | Last window closed on timeout |
| done_o | output | 1 | One-cycle strobe when a window closes |

## Verification
On every cycle, the assertions check four things: that `done_o` is a single-cycle pulse that only follows an open window, that hit and timeout are exclusive at close, that a timeout reports zero, and that a hit never reports more than the latched length. They also check that the result outputs stay stable between closes. Some behaviours can only be shown by the bench's scenarios: the exact closing edge and elapsed value against the trigger-to-event distance, the two-flop latency on both inputs, ignored early events, retriggering, the disarmed trigger, the latched length, and the L=0 and maximum-length windows.

// File: rtl/wet_pkg.sv
// Shared types of the windowed event timer.
// Assumes: nothing beyond IEEE 1800-2017.
package wet_pkg;
    typedef enum logic {
        WET_IDLE   = 1'b0,
        WET_ACTIVE = 1'b1
    } wet_state_e;
endpackage

// File: rtl/wet_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous inputs.
// Assumes: each bit is an independent level; no bus coherency is implied.
module wet_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end
endmodule

// File: rtl/wet_edge.sv
// Per-bit edge detector; FALL_MASK bit set selects falling, clear selects rising.
// Assumes: inputs are already synchronous to clk.
module wet_edge #(
    parameter int         W         = 2,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] edge_o
);
    logic [W-1:0] prev_q;

    // Remember last level of every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_det
        if (FALL_MASK[i]) begin : g_fall
            assign edge_o[i] = prev_q[i] & ~lvl_i[i];
        end else begin : g_rise
            assign edge_o[i] = ~prev_q[i] & lvl_i[i];
        end
    end
endmodule

// File: rtl/wet_phase.sv
// Phase register: loaded with the window length, then stepped by -1 per clock.
// Assumes: load has priority over stepping; the MSB is the sign/timeout bit.
module wet_phase #(
    parameter int LEN_W = 15,
    localparam int PH_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             sign_o
);
    // Preload on window start, count down while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_o <= '0;
        else if (load_i) phase_o <= {1'b0, len_i};
        else if (run_i)  phase_o <= phase_o - PH_W'(1);
    end

    assign sign_o = phase_o[PH_W-1];
endmodule

// File: rtl/wet_ctrl.sv
// Window controller: opens, restarts and closes windows and registers results.
// Assumes: start, evt_rise and sign are synchronous single-cycle or level inputs;
// a restart wins over a close on the same edge; timeout wins over an event.
module wet_ctrl
    import wet_pkg::*;
#(
    parameter int LEN_W    = 15,
    parameter int LAT_COMP = 1,
    localparam int PH_W    = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             evt_rise_i,
    input  logic             sign_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic             busy_o,
    output logic [LEN_W-1:0] len_q_o,
    output logic [LEN_W-1:0] elapsed_o,
    output logic             hit_o,
    output logic             timeout_o,
    output logic             done_o
);
    localparam logic [PH_W-1:0] COMP = PH_W'(LAT_COMP);

    wet_state_e        state_q;
    logic [PH_W-1:0]   diff;
    logic [LEN_W-1:0]  elapsed_d;

    // Raw elapsed time from the captured residue, compensated and clamped at zero.
    always_comb begin
        diff = {1'b0, len_q_o} - phase_i;
        if (diff > COMP) elapsed_d = LEN_W'(diff - COMP);
        else             elapsed_d = '0;
    end

    // Window state machine and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= WET_IDLE;
            len_q_o   <= '0;
            elapsed_o <= '0;
            hit_o     <= 1'b0;
            timeout_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                WET_IDLE: begin
                    if (start_i) begin
                        state_q <= WET_ACTIVE;
                        len_q_o <= win_len_i;
                    end
                end
                default: begin
                    if (start_i) begin
                        len_q_o <= win_len_i;
                    end else if (sign_i) begin
                        state_q   <= WET_IDLE;
                        done_o    <= 1'b1;
                        timeout_o <= 1'b1;
                        hit_o     <= 1'b0;
                        elapsed_o <= '0;
                    end else if (evt_rise_i) begin
                        state_q   <= WET_IDLE;
                        done_o    <= 1'b1;
                        timeout_o <= 1'b0;
                        hit_o     <= 1'b1;
                        elapsed_o <= elapsed_d;
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q == WET_ACTIVE);
endmodule

// File: rtl/win_event_timer.sv
// Windowed event timer top: synchronises trigger and event, detects edges,
// runs the down-counting phase register and reports the first event per window.
// Assumes: arm_i and win_len_i are synchronous to clk.
module win_event_timer #(
    parameter int LEN_W    = 15,
    parameter int LAT_COMP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             evt_i,
    input  logic             arm_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic [LEN_W-1:0] elapsed_o,
    output logic             hit_o,
    output logic             timeout_o,
    output logic             done_o
);
    localparam int PH_W = LEN_W + 1;

    logic [1:0]       lvl;
    logic [1:0]       edg;
    logic             start;
    logic             busy;
    logic             sign;
    logic [PH_W-1:0]  phase;
    logic [LEN_W-1:0] len_q;

    wet_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({evt_i, trig_i}),
        .sync_o  (lvl)
    );

    // Bit 0 is the trigger (falling), bit 1 the event (rising).
    wet_edge #(.W(2), .FALL_MASK(2'b01)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .edge_o (edg)
    );

    assign start = edg[0] & arm_i;

    wet_phase #(.LEN_W(LEN_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .run_i   (busy),
        .len_i   (win_len_i),
        .phase_o (phase),
        .sign_o  (sign)
    );

    wet_ctrl #(.LEN_W(LEN_W), .LAT_COMP(LAT_COMP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .evt_rise_i (edg[1]),
        .sign_i     (sign),
        .phase_i    (phase),
        .win_len_i  (win_len_i),
        .busy_o     (busy),
        .len_q_o    (len_q),
        .elapsed_o  (elapsed_o),
        .hit_o      (hit_o),
        .timeout_o  (timeout_o),
        .done_o     (done_o)
    );
endmodule

// File: rtl/win_event_timer_chk.sv
// Assertion checker for the windowed event timer, attached by bind.
// Assumes: sees the top's outputs plus its busy flag and latched length.
module win_event_timer_chk #(
    parameter int LEN_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_o,
    input logic             hit_o,
    input logic             timeout_o,
    input logic [LEN_W-1:0] elapsed_o,
    input logic             busy,
    input logic [LEN_W-1:0] len_q
);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    assert_outcome_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (hit_o ^ timeout_o));

    assert_timeout_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> (elapsed_o == '0));

    assert_hit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> (elapsed_o <= len_q));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(elapsed_o) && $stable(hit_o) && $stable(timeout_o)));
endmodule

bind win_event_timer win_event_timer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_o    (done_o),
    .hit_o     (hit_o),
    .timeout_o (timeout_o),
    .elapsed_o (elapsed_o),
    .busy      (busy),
    .len_q     (len_q)
);

// File: tb/win_event_timer_bench.sv
// Self-checking bench: directed corners plus seeded random windows.
module win_event_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 15;
    localparam int MAX_LEN    = (1 << LEN_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_i = 1'b1;
    logic             evt_i = 1'b0;
    logic             arm_i = 1'b1;
    logic [LEN_W-1:0] win_len_i = '0;
    logic [LEN_W-1:0] elapsed_o;
    logic             hit_o;
    logic             timeout_o;
    logic             done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    win_event_timer #(.LEN_W(LEN_W), .LAT_COMP(1)) u_win_event_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .evt_i     (evt_i),
        .arm_i     (arm_i),
        .win_len_i (win_len_i),
        .elapsed_o (elapsed_o),
        .hit_o     (hit_o),
        .timeout_o (timeout_o),
        .done_o    (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outcome from trigger-relative event distance dd and length len.
    function automatic bit exp_hit(input int len, input int dd);
        return (dd >= 1) && (dd <= len + 1);
    endfunction

    function automatic int exp_elapsed(input int len, input int dd);
        if (!exp_hit(len, dd)) return 0;
        return (dd - 2 > 0) ? dd - 2 : 0;
    endfunction

    // One window: trigger falls before edge k=0, event rises before edge k=d,
    // optional restart fall at k=rt, optional length change at k=3.
    task automatic run_win(input int len, input int d, input int rt, input bit chg, input string req);
        int  base  = (rt > 0) ? rt : 0;
        int  dd    = d - base;
        bit  eh    = exp_hit(len, dd);
        int  xedge = eh ? d + 2 : base + len + 4;
        int  kmin  = (d < 0) ? d : 0;
        int  kdone = -1000;
        bit  stray = 1'b0;
        int  e_el;
        bit  e_h;
        bit  e_t;
        win_len_i = LEN_W'(len);
        for (int k = kmin; k <= base + len + 24; k++) begin
            @(negedge clk);
            if (done_o) begin
                kdone = k;
                break;
            end
            if (k == d) evt_i = 1'b1;
            if (k == 0) trig_i = 1'b0;
            if (rt > 0 && k == rt - 4) trig_i = 1'b1;
            if (rt > 0 && k == rt) trig_i = 1'b0;
            if (chg && k == 3) win_len_i = ~LEN_W'(len);
        end
        check(kdone - 1 == xedge, {req, " done edge"}, kdone - 1, xedge);
        check(hit_o == eh, {req, " hit"}, int'(hit_o), int'(eh));
        check(timeout_o == !eh, {req, " timeout"}, int'(timeout_o), int'(!eh));
        check(int'(elapsed_o) == exp_elapsed(len, dd), {req, " elapsed"},
              int'(elapsed_o), exp_elapsed(len, dd));
        e_el = int'(elapsed_o);
        e_h  = hit_o;
        e_t  = timeout_o;
        @(negedge clk);
        check(!done_o, "R6 done single cycle", int'(done_o), 0);
        // Stray event rise after close must not produce a result (R6, R4).
        evt_i = 1'b0;
        repeat (2) @(negedge clk);
        evt_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done_o) stray = 1'b1;
        end
        check(!stray, "R6 no done after close", int'(stray), 0);
        check(int'(elapsed_o) == e_el && hit_o == e_h && timeout_o == e_t,
              "R8 results held", int'(elapsed_o), e_el);
        evt_i     = 1'b0;
        trig_i    = 1'b1;
        win_len_i = LEN_W'(len);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        wait (cyc >= 190000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        check(!done_o && !hit_o && !timeout_o && elapsed_o == '0, "R1 reset outputs",
              int'(elapsed_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!done_o && !hit_o && !timeout_o && elapsed_o == '0, "R1 after reset",
              int'(done_o), 0);

        // R2/R3: basic hits at several distances.
        run_win(20, 5, 0, 1'b0, "R2 R3 mid hit");
        run_win(20, 1, 0, 1'b0, "R3 earliest hit");
        run_win(20, 2, 0, 1'b0, "R3 d=2 clamp");
        run_win(20, 21, 0, 1'b0, "R3 last hit");
        // R5: event one cycle too late, no event at all, length zero.
        run_win(20, 22, 0, 1'b0, "R5 late event");
        run_win(10, 500, 0, 1'b0, "R5 no event");
        run_win(0, 1, 0, 1'b0, "R5 len0 hit");
        run_win(0, 2, 0, 1'b0, "R5 len0 timeout");
        // R4: event already risen before the window opens.
        run_win(15, 0, 0, 1'b0, "R4 event at trigger");
        run_win(15, -3, 0, 1'b0, "R4 early event");
        // R7: restart mid window.
        run_win(30, 20, 10, 1'b0, "R7 retrigger hit");
        run_win(30, 999, 10, 1'b0, "R7 retrigger timeout");
        // R10: length changed after opening.
        run_win(12, 8, 0, 1'b1, "R10 latched length hit");
        run_win(12, 999, 0, 1'b1, "R10 latched length timeout");

        // R9: disarmed trigger opens nothing.
        arm_i = 1'b0;
        win_len_i = LEN_W'(3);
        trig_i = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (i == 8) evt_i = 1'b1;
            if (done_o) seen = 1'b1;
        end
        check(!seen, "R9 disarmed trigger", int'(seen), 0);
        trig_i = 1'b1;
        evt_i  = 1'b0;
        repeat (4) @(negedge clk);
        arm_i = 1'b1;
        run_win(6, 4, 0, 1'b0, "R9 rearmed hit");

        // R5: largest window length times out.
        run_win(MAX_LEN, MAX_LEN + 100, 0, 1'b0, "R5 max length");

        // Random windows.
        for (int n = 0; n < 40; n++) begin
            int len = int'($urandom_range(0, 60));
            int d   = int'($urandom_range(0, len + 9)) - 3;
            run_win(len, d, 0, 1'b0, "R3 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule